// File: doc/BRIEF.md
# Scan Chain Snapshot Controller

This block swaps the complete register state of a group of instrumented peripherals in one operation. Every flip-flop of those peripherals sits on a single serial shift path. While the controller asserts the shift control, one bit moves in at the head of the path and one bit leaves at its tail on each clock. Software writes three registers: the SRAM word address of the state to load, the SRAM word address where the outgoing state goes, and the chain length in bits. It then sets the start bit.

Once started, the controller stops the peripherals' functional clock enable and steps through the chain one 32-bit SRAM word at a time. For each word it reads the word holding the new state and shifts those bits in. In the same shift cycles it collects the bits coming out and writes them back as one packed word. The captured state and the restored state cross the chain in the same pass. No software runs during the transfer, because all data stays in the local SRAM. When the counted length has been shifted, the controller lets the peripherals run again and raises a sticky done flag.

The SRAM port has a fixed latency and no back-pressure. A read issued in one cycle returns its data on the next cycle, and a write completes in the cycle it is issued. The port has no valid/ready handshake because the SRAM can never stall.

Top module: `scan_snap_ctrl`

## Requirements
- R1: After reset, busy and done read 0, `periph_run` is 1 and `chain_shift` is 0.
- R2: The register offsets are on `reg_addr`. At 0x00, writing bit 0 = 1 starts an operation. At 0x04 the status reads busy in bit 0 and done in bit 1. 0x08 is the source word address, 0x0C is the destination word address and 0x10 is the chain length in bits. The last three read back exactly what was written.
- R3: `periph_run` is 0 from the cycle after the start write until the operation ends. `chain_shift` is asserted only while `periph_run` is 0.
- R4: During one operation, `chain_shift` is high for exactly the programmed length, counted in cycles.
- R5: Restore: bit i of the SRAM word at source+k is the (32k+i)-th bit driven on `chain_din`, counting from 0. After the operation, chain position 32k+i holds that bit.
- R6: Capture: the j-th bit seen on `chain_dout` during shifting is stored at destination+j/32, bit j%32. Unused upper bits of a final partial word are written as 0.
- R7: Done sets when an operation completes and stays set until software writes 0x04 with bit 1 = 1. Writing 0x04 with bit 1 = 0 leaves it set.
- R8: A start write while busy has no effect. The running operation keeps the length, source and destination it started with.
- R9: A start with length 0 sets done without asserting `chain_shift` and without any SRAM access.
- R10: There is at most one SRAM access per cycle, and there is no SRAM access or shifting while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Sticky completion flag |
| sram_rd_en | output | 1 | SRAM read request |
| sram_rd_addr | output | AW | SRAM read word address |
| sram_rd_data | input | 32 | SRAM read data, one cycle after the request |
| sram_wr_en | output | 1 | SRAM write strobe |
| sram_wr_addr | output | AW | SRAM write word address |
| sram_wr_data | output | 32 | SRAM write data |
| chain_shift | output | 1 | Puts every chain flip-flop in shift mode |
| chain_din | output | 1 | Bit entering the head of the chain |
| chain_dout | input | 1 | Bit leaving the tail of the chain |
| periph_run | output | 1 | Functional clock enable of the peripherals; 0 freezes them |

## Verification
The checker assumes three things about its inputs. Software does not write the length register between its start write and the end of the operation, except in the busy-start case that R8 covers. The length fits the chain actually attached. The source and destination regions lie inside the SRAM. The bench always programs the length equal to the length of its chain model. It keeps every address region within its 64-word memory. It changes the length during an operation only in the R8 scenario, where the checker counts against the length captured at start.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_IW = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SHIFT,
    ST_STORE
  } snap_state_e;

  // Register index taken from reg_addr[4:2].
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_SRC  = 3'd2;
  localparam logic [2:0] IDX_DST  = 3'd3;
  localparam logic [2:0] IDX_LEN  = 3'd4;
endpackage

// File: rtl/snap_regs.sv
module snap_regs
  import snap_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic          finish,
  output logic          go,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [LW-1:0] len_q,
  output logic          done
);
  logic [2:0] idx;
  assign idx = reg_addr[4:2];
  assign go  = reg_we && (idx == IDX_CTRL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      done  <= 1'b0;
    end else begin
      if (reg_we && idx == IDX_SRC) src_q <= reg_wdata[AW-1:0];
      if (reg_we && idx == IDX_DST) dst_q <= reg_wdata[AW-1:0];
      if (reg_we && idx == IDX_LEN) len_q <= reg_wdata[LW-1:0];
      if (finish) done <= 1'b1;
      else if (reg_we && idx == IDX_STAT && reg_wdata[1]) done <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (idx)
      IDX_STAT: reg_rdata[1:0] = {done, busy};
      IDX_SRC:  reg_rdata[AW-1:0] = src_q;
      IDX_DST:  reg_rdata[AW-1:0] = dst_q;
      IDX_LEN:  reg_rdata[LW-1:0] = len_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/snap_seq.sv
module snap_seq
  import snap_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     src,
  input  logic [AW-1:0]     dst,
  input  logic [LW-1:0]     len,
  output logic              busy,
  output logic              finish,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              load,
  output logic              shift,
  output logic [BIT_IW-1:0] bit_idx
);
  snap_state_e st;
  logic [AW-1:0] src_b, dst_b, word_idx;
  logic [LW-1:0] remain;

  assign busy    = (st != ST_IDLE);
  assign rd_en   = (st == ST_FETCH);
  assign load    = (st == ST_LOAD);
  assign shift   = (st == ST_SHIFT);
  assign wr_en   = (st == ST_STORE);
  assign rd_addr = src_b + word_idx;
  assign wr_addr = dst_b + word_idx;
  assign finish  = (st == ST_STORE && remain == '0) ||
                   (st == ST_IDLE && go && len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src_b    <= '0;
      dst_b    <= '0;
      word_idx <= '0;
      remain   <= '0;
      bit_idx  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go && len != '0) begin
          src_b    <= src;
          dst_b    <= dst;
          remain   <= len;
          word_idx <= '0;
          st       <= ST_FETCH;
        end
        ST_FETCH: st <= ST_LOAD;
        ST_LOAD: begin
          bit_idx <= '0;
          st      <= ST_SHIFT;
        end
        ST_SHIFT: begin
          bit_idx <= bit_idx + 1'b1;
          remain  <= remain - 1'b1;
          if (remain == LW'(1) || bit_idx == BIT_IW'(WORD_W - 1)) st <= ST_STORE;
        end
        ST_STORE: begin
          word_idx <= word_idx + 1'b1;
          st       <= (remain == '0) ? ST_IDLE : ST_FETCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snap_pack.sv
module snap_pack
  import snap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              shift,
  input  logic [BIT_IW-1:0] bit_idx,
  input  logic              dout,
  output logic              din,
  output logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] in_buf, out_buf;

  assign din     = shift & in_buf[bit_idx];
  assign wr_data = out_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_buf  <= '0;
      out_buf <= '0;
    end else if (load) begin
      in_buf  <= rd_data;
      out_buf <= '0;
    end else if (shift) begin
      out_buf[bit_idx] <= dout;
    end
  end
endmodule

// File: rtl/scan_snap_ctrl.sv
module scan_snap_ctrl
  import snap_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          busy,
  output logic          done,
  output logic          sram_rd_en,
  output logic [AW-1:0] sram_rd_addr,
  input  logic [31:0]   sram_rd_data,
  output logic          sram_wr_en,
  output logic [AW-1:0] sram_wr_addr,
  output logic [31:0]   sram_wr_data,
  output logic          chain_shift,
  output logic          chain_din,
  input  logic          chain_dout,
  output logic          periph_run
);
  logic go, finish, load;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] len_q;
  logic [BIT_IW-1:0] bit_idx;

  assign periph_run = !busy;

  snap_regs #(.AW(AW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .finish(finish), .go(go), .src_q(src_q), .dst_q(dst_q),
    .len_q(len_q), .done(done)
  );

  snap_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .src(src_q), .dst(dst_q),
    .len(len_q), .busy(busy), .finish(finish), .rd_en(sram_rd_en),
    .rd_addr(sram_rd_addr), .wr_en(sram_wr_en), .wr_addr(sram_wr_addr),
    .load(load), .shift(chain_shift), .bit_idx(bit_idx)
  );

  snap_pack u_pack (
    .clk(clk), .rst_n(rst_n), .load(load), .rd_data(sram_rd_data),
    .shift(chain_shift), .bit_idx(bit_idx), .dout(chain_dout),
    .din(chain_din), .wr_data(sram_wr_data)
  );
endmodule

// File: rtl/snap_chk.sv
module snap_chk #(
  parameter int LW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        busy,
  input logic        done,
  input logic        periph_run,
  input logic        chain_shift,
  input logic        sram_rd_en,
  input logic        sram_wr_en
);
  logic        start_wr;
  logic [31:0] len_seen, len_lat, shift_cnt;

  assign start_wr = reg_we && reg_addr[4:2] == 3'd0 && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_seen  <= '0;
      len_lat   <= '0;
      shift_cnt <= '0;
    end else begin
      if (reg_we && reg_addr[4:2] == 3'd4) len_seen <= 32'(reg_wdata[LW-1:0]);
      if (start_wr && !busy) begin
        len_lat   <= len_seen;
        shift_cnt <= '0;
      end else if (chain_shift) begin
        shift_cnt <= shift_cnt + 1;
      end
    end
  end

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_shift |-> !periph_run);
  assert_shift_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> shift_cnt == len_lat);
  assert_done_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !busy && len_seen == 0) |=> (done && !busy && !chain_shift));
  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_rd_en && sram_wr_en));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(sram_rd_en || sram_wr_en || chain_shift));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_wr));
endmodule

bind scan_snap_ctrl snap_chk #(.LW(LW)) u_snap_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .done(done), .periph_run(periph_run),
  .chain_shift(chain_shift), .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en)
);

// File: tb/tb_scan_snap_ctrl.sv
module tb_scan_snap_ctrl;
  localparam int AW = 6;
  localparam int LW = 16;
  localparam int MAXC = 128;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic busy, done, sram_rd_en, sram_wr_en, chain_shift, chain_din, chain_dout, periph_run;
  logic [AW-1:0] sram_rd_addr, sram_wr_addr;
  logic [31:0] sram_rd_data, sram_wr_data;

  int n_chk = 0, n_bad = 0;
  int cl = 1;
  int scnt = 0, frz_bad = 0, mem_acc_idle = 0;
  logic chain [MAXC];
  logic [31:0] mem [64];
  logic old_chain [MAXC];

  always #4 clk = ~clk;

  scan_snap_ctrl #(.AW(AW), .LW(LW)) dut (.*);

  assign chain_dout = chain[0];

  always @(posedge clk) begin
    if (chain_shift)
      for (int i = 0; i < MAXC; i++) begin
        if (i < cl - 1) chain[i] <= chain[i+1];
        else if (i == cl - 1) chain[i] <= chain_din;
      end
    if (sram_rd_en) sram_rd_data <= mem[sram_rd_addr];
    if (sram_wr_en) mem[sram_wr_addr] <= sram_wr_data;
    if (chain_shift) scnt <= scnt + 1;
    if (busy && periph_run) frz_bad <= frz_bad + 1;
    if (!busy && (sram_rd_en || sram_wr_en)) mem_acc_idle <= mem_acc_idle + 1;
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin @(posedge clk); #1; g++; end
  endtask

  // Runs one transfer and checks data both ways (R4, R5, R6, R3).
  task automatic xfer(input int len, input int src, input int dst);
    logic [31:0] exp_w;
    cl = len;
    for (int i = 0; i < MAXC; i++) begin
      chain[i] = $urandom_range(0, 1);
      old_chain[i] = chain[i];
    end
    for (int w = 0; w < 4; w++) begin
      mem[src+w] = $urandom;
      mem[dst+w] = 32'hFFFF_FFFF;
    end
    wr(5'h08, src); wr(5'h0C, dst); wr(5'h10, len);
    scnt = 0; frz_bad = 0;
    wr(5'h00, 1);
    check(periph_run == 0, "R3 frozen after start", periph_run, 0);
    wait_idle();
    @(posedge clk); #1;
    check(scnt == len, "R4 shift count", scnt, len);
    check(frz_bad == 0, "R3 run while busy", frz_bad, 0);
    check(periph_run == 1, "R3 released", periph_run, 1);
    for (int w = 0; w < (len + 31) / 32; w++) begin
      exp_w = '0;
      for (int b = 0; b < 32; b++)
        if (w*32 + b < len) exp_w[b] = old_chain[w*32 + b];
      check(mem[dst+w] == exp_w, "R6 captured word", mem[dst+w], exp_w);
    end
    begin
      int bad = 0;
      for (int i = 0; i < len; i++)
        if (chain[i] !== mem[src + i/32][i%32]) bad++;
      check(bad == 0, "R5 restored bits", bad, 0);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h04, d);
    check(d[1:0] == 2'b00, "R1 status", d, 0);
    check(periph_run == 1 && chain_shift == 0, "R1 pins", {periph_run, chain_shift}, 2'b10);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5'h08, 32'h15); wr(5'h0C, 32'h2A); wr(5'h10, 32'h1234);
    rd(5'h08, d); check(d == 32'h15, "R2 src readback", d, 32'h15);
    rd(5'h0C, d); check(d == 32'h2A, "R2 dst readback", d, 32'h2A);
    rd(5'h10, d); check(d == 32'h1234, "R2 len readback", d, 32'h1234);
  endtask

  task automatic t_done_w1c();
    logic [31:0] d;
    rd(5'h04, d); check(d[1:0] == 2'b10, "R7 done sticky", d, 2);
    wr(5'h04, 32'h1);
    rd(5'h04, d); check(d[1] == 1, "R7 write 0 keeps", d[1], 1);
    wr(5'h04, 32'h2);
    rd(5'h04, d); check(d[1] == 0, "R7 w1c clears", d[1], 0);
  endtask

  task automatic t_busy_start();
    cl = 40;
    for (int i = 0; i < MAXC; i++) begin chain[i] = i[0]; old_chain[i] = chain[i]; end
    mem[0] = 32'hA5A5_0F0F; mem[1] = 32'h0000_00C3;
    wr(5'h08, 0); wr(5'h0C, 8); wr(5'h10, 40);
    scnt = 0;
    wr(5'h00, 1);
    repeat (5) @(posedge clk);
    wr(5'h10, 8); wr(5'h0C, 20); wr(5'h00, 1);
    wait_idle();
    @(posedge clk); #1;
    check(scnt == 40, "R8 length kept", scnt, 40);
    check(mem[9][7:0] == {old_chain[39], old_chain[38], old_chain[37], old_chain[36],
                          old_chain[35], old_chain[34], old_chain[33], old_chain[32]},
          "R8 destination kept", mem[9], 0);
    check(busy == 0, "R8 no restart", busy, 0);
    wr(5'h04, 2);
  endtask

  task automatic t_zero_len();
    logic [31:0] d;
    wr(5'h10, 0);
    scnt = 0; mem_acc_idle = 0;
    wr(5'h00, 1);
    rd(5'h04, d);
    check(d[1:0] == 2'b10, "R9 done no busy", d, 2);
    check(scnt == 0, "R9 no shifts", scnt, 0);
    check(mem_acc_idle == 0, "R10 idle access", mem_acc_idle, 0);
    wr(5'h04, 2);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXC; i++) chain[i] = 0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    sram_rd_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_regs();
    xfer(64, 0, 16);
    t_done_w1c();
    xfer(45, 4, 24);
    wr(5'h04, 2);
    xfer(33, 30, 40);
    wr(5'h04, 2);
    t_busy_start();
    t_zero_len();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule